// File: doc/BRIEF.md
# Flash Sector-Erase Command Sequencer

This block sits on the host write path of a flash-style memory and decodes the multi-cycle sector-erase command. It sees one pulse on `wrStrobe` for each completed host write, together with the address and data of that write. A complete six-write sequence selects one sector. That sequence is two unlock writes, a setup write, two more unlock writes, and a sector data write. The sector data write opens a collection window. While the window is open, the host can add more sectors. The window restarts on every accepted write. When no write arrives for `WINDOW_CYCLES` clocks, the block pulses `startErase` and hands the collected one-hot sector mask to a downstream erase engine.

Inside the window, an extra sector can be named in three ways: a bare sector data write, the last three writes of the sequence, or the full six-write sequence. A suspend code is tolerated. Any other write inside the window cancels the whole operation and returns to read mode. Outside the window, a broken sequence only resets the sequencer. The host can poll `windowClosed` to learn whether sectors are still being accepted.

The unlock addresses, the unlock data values and the command codes are parameters. The sector number is the top `log2(NUM_SECT)` bits of the address of a sector data write.

Top module: `erase_seq_decoder`

## Requirements
- R1: After reset, `windowClosed` is 1, `sectorMask` is 0 and `startErase` is 0.
- R2: A valid sequence opens the window. That sequence is write (UNLOCK_ADDR_A, UNLOCK_DATA_A), then (UNLOCK_ADDR_B, UNLOCK_DATA_B), then (UNLOCK_ADDR_A, SETUP_CMD), then the two unlock writes again, then a write of SECTOR_CMD at any address. In the cycle after the last write, `windowClosed` is 0 and `sectorMask` holds only bit s. Here s is the address bits [ADDR_W-1 -: log2(NUM_SECT)].
- R3: While the window is open, a SECTOR_CMD write at any address ORs its sector bit into `sectorMask`. Sectors may be given in any order, and any number of them may be given.
- R4: The window closes `WINDOW_CYCLES` clocks after the last accepted write. A write whose edge comes exactly `WINDOW_CYCLES` clocks after the previous one is still accepted and restarts the count. On closing, `startErase` is 1 for exactly one cycle and `windowClosed` becomes 1 in that same cycle.
- R5: While the window is open, a full repeat of the six-write sequence adds its sector.
- R6: While the window is open, the three writes (UNLOCK_ADDR_A, UNLOCK_DATA_A), (UNLOCK_ADDR_B, UNLOCK_DATA_B), SECTOR_CMD add the sector of the third write.
- R7: While the window is open, a write that is not SECTOR_CMD, not SUSPEND_CMD and not the first unlock write cancels the operation. `windowClosed` becomes 1, `sectorMask` becomes 0, and `startErase` never pulses.
- R8: A SUSPEND_CMD write inside the window neither cancels the operation nor changes `sectorMask`.
- R9: Outside the window, a write that breaks the sequence returns the sequencer to idle and leaves `sectorMask` unchanged. A complete sequence given afterwards is accepted.
- R10: `sectorMask` keeps its value after `startErase`. The first sector data write of the next sequence replaces it.
- R11: Inside the window, a repeat sequence broken part-way cancels the operation as in R7.
- R12: Outside the window, a lone SECTOR_CMD write is ignored. The window stays closed, `sectorMask` is unchanged and no `startErase` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle pulse per completed host write |
| wrAddr | input | ADDR_W | Address of the host write |
| wrData | input | 8 | Data of the host write |
| startErase | output | 1 | One-cycle pulse when the window closes |
| sectorMask | output | NUM_SECT | One bit per sector selected for erase |
| windowClosed | output | 1 | 1 when no sector collection window is open |

## Verification
Several rules are checked on every cycle. `startErase` never lasts more than one cycle. It only coincides with the window closing, and never follows an edge that carried a write. The mask only moves on a write edge, and it is never empty while the window is open. The window only opens on a write. The bench scenarios cover the rest:
- decoding of each follow-up form;
- the exact expiry cycle and the boundary write that lands on it;
- cancellation by foreign or broken writes;
- the difference between mismatches inside and outside the window.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_SETUP, S_UNL4, S_UNL5, S_WIN
  } seqState_t;

  // strobes from the sequencer to the window/mask datapath
  typedef struct packed {
    logic openWin;    // first sector of a new operation
    logic addSector;  // extra sector while window open
    logic reload;     // accepted write inside window
    logic abortWin;   // cancel operation
  } dpCtrl_t;

endpackage

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_A = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_B = 12'h2AA,
  parameter logic [7:0] UNLOCK_DATA_A = 8'hAA,
  parameter logic [7:0] UNLOCK_DATA_B = 8'h55,
  parameter logic [7:0] SETUP_CMD = 8'h80,
  parameter logic [7:0] SECTOR_CMD = 8'h30,
  parameter logic [7:0] SUSPEND_CMD = 8'hB0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              armed,
  input  logic              expire,
  output dpCtrl_t           ctl
);

  seqState_t state, nxt;
  logic hitU1, hitU2, hitSetup, hitSect, hitSusp, fail;

  assign hitU1    = (wrAddr == UNLOCK_ADDR_A) && (wrData == UNLOCK_DATA_A);
  assign hitU2    = (wrAddr == UNLOCK_ADDR_B) && (wrData == UNLOCK_DATA_B);
  assign hitSetup = (wrAddr == UNLOCK_ADDR_A) && (wrData == SETUP_CMD);
  assign hitSect  = (wrData == SECTOR_CMD);
  assign hitSusp  = (wrData == SUSPEND_CMD);

  always_comb begin
    nxt  = state;
    ctl  = '0;
    fail = 1'b0;
    if (expire) begin
      nxt = S_IDLE;
    end else if (wrStrobe) begin
      case (state)
        S_IDLE:  if (hitU1) nxt = S_UNL1;
        S_UNL1:  if (hitU2) nxt = S_UNL2; else fail = 1'b1;
        S_UNL2: begin
          if (hitSetup) nxt = S_SETUP;
          else if (armed && hitSect) begin
            ctl.addSector = 1'b1;
            nxt = S_WIN;
          end else fail = 1'b1;
        end
        S_SETUP: if (hitU1) nxt = S_UNL4; else fail = 1'b1;
        S_UNL4:  if (hitU2) nxt = S_UNL5; else fail = 1'b1;
        S_UNL5: begin
          if (hitSect) begin
            if (armed) ctl.addSector = 1'b1;
            else       ctl.openWin   = 1'b1;
            nxt = S_WIN;
          end else fail = 1'b1;
        end
        S_WIN: begin
          if (hitSect)      ctl.addSector = 1'b1;
          else if (hitU1)   nxt = S_UNL1;
          else if (!hitSusp) fail = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
      if (fail) begin
        nxt          = S_IDLE;
        ctl.abortWin = armed;
      end
      ctl.reload = armed && !fail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int NUM_SECT      = 8,
  parameter int WINDOW_CYCLES = 2500,
  localparam int SEC_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStrobe,
  input  logic [SEC_W-1:0]    secIdx,
  input  dpCtrl_t             ctl,
  output logic                armed,
  output logic                expire,
  output logic                startErase,
  output logic [NUM_SECT-1:0] sectorMask
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0]    cnt;
  logic [NUM_SECT-1:0] secBit;

  for (genvar g = 0; g < NUM_SECT; g++) begin : gDecode
    assign secBit[g] = (secIdx == SEC_W'(g));
  end

  assign expire = armed && (cnt == '0) && !wrStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      cnt        <= '0;
      sectorMask <= '0;
      startErase <= 1'b0;
    end else begin
      startErase <= 1'b0;
      if (ctl.openWin) begin
        sectorMask <= secBit;
        armed      <= 1'b1;
        cnt        <= LOAD;
      end else if (ctl.abortWin) begin
        sectorMask <= '0;
        armed      <= 1'b0;
      end else if (expire) begin
        armed      <= 1'b0;
        startErase <= 1'b1;
      end else if (armed) begin
        if (ctl.addSector) sectorMask <= sectorMask | secBit;
        if (ctl.reload) cnt <= LOAD;
        else            cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/erase_seq_decoder.sv
module erase_seq_decoder
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int NUM_SECT      = 8,
  parameter int WINDOW_CYCLES = 2500,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_A = 12'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR_B = 12'h2AA,
  parameter logic [7:0] UNLOCK_DATA_A = 8'hAA,
  parameter logic [7:0] UNLOCK_DATA_B = 8'h55,
  parameter logic [7:0] SETUP_CMD     = 8'h80,
  parameter logic [7:0] SECTOR_CMD    = 8'h30,
  parameter logic [7:0] SUSPEND_CMD   = 8'hB0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStrobe,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [7:0]          wrData,
  output logic                startErase,
  output logic [NUM_SECT-1:0] sectorMask,
  output logic                windowClosed
);

  localparam int SEC_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

  dpCtrl_t ctl;
  logic    armed, expire;

  erase_seq_ctrl #(
    .ADDR_W(ADDR_W), .UNLOCK_ADDR_A(UNLOCK_ADDR_A), .UNLOCK_ADDR_B(UNLOCK_ADDR_B),
    .UNLOCK_DATA_A(UNLOCK_DATA_A), .UNLOCK_DATA_B(UNLOCK_DATA_B),
    .SETUP_CMD(SETUP_CMD), .SECTOR_CMD(SECTOR_CMD), .SUSPEND_CMD(SUSPEND_CMD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .armed(armed), .expire(expire), .ctl(ctl)
  );

  erase_seq_dp #(
    .NUM_SECT(NUM_SECT), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe),
    .secIdx(wrAddr[ADDR_W-1 -: SEC_W]), .ctl(ctl), .armed(armed),
    .expire(expire), .startErase(startErase), .sectorMask(sectorMask)
  );

  assign windowClosed = ~armed;

endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrStrobe,
  input logic                startErase,
  input logic [NUM_SECT-1:0] sectorMask,
  input logic                windowClosed
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startErase |=> !startErase); // R4

  AST_START_AT_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startErase) |-> (windowClosed && $past(!windowClosed))); // R4

  AST_NO_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !startErase); // R4

  AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(sectorMask)); // R10

  AST_MASK_NONEMPTY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !windowClosed |-> (sectorMask != '0)); // R3

  AST_OPEN_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(windowClosed) |-> $past(wrStrobe)); // R2

endmodule

bind erase_seq_decoder erase_seq_checker #(.NUM_SECT(NUM_SECT)) uChk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .startErase(startErase),
  .sectorMask(sectorMask), .windowClosed(windowClosed)
);

// File: tb/erase_seq_decoder_test.sv
module erase_seq_decoder_test;

  localparam int ADDR_W = 12;
  localparam int NS     = 8;
  localparam int W      = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrStrobe = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          startErase;
  logic [NS-1:0] sectorMask;
  logic          windowClosed;
  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk; // 50 MHz

  erase_seq_decoder #(.ADDR_W(ADDR_W), .NUM_SECT(NS), .WINDOW_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .startErase(startErase), .sectorMask(sectorMask),
    .windowClosed(windowClosed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] secAddr(input int s);
    return {s[2:0], 9'h1A4};
  endfunction

  task automatic fullSeq(input int s);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(secAddr(s), 8'h30);
  endtask

  task automatic shortSeq(input int s);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(secAddr(s), 8'h30);
  endtask

  // wait up to W+5 cycles; report whether startErase was seen
  task automatic waitStart(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < W + 5; i++) begin
      @(negedge clk);
      if (startErase) seen = 1'b1;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(windowClosed == 1'b1, "R1 closed", int'(windowClosed), 1);
    check(sectorMask == '0, "R1 mask", int'(sectorMask), 0);
    check(startErase == 1'b0, "R1 start", int'(startErase), 0);
  endtask

  task automatic testSingle();
    fullSeq(5);
    check(windowClosed == 1'b0, "R2 open", int'(windowClosed), 0);
    check(sectorMask == 8'h20, "R2 mask", int'(sectorMask), 'h20);
    repeat (W - 1) @(negedge clk);
    check(startErase == 1'b0 && windowClosed == 1'b0, "R4 early",
          int'({startErase, windowClosed}), 0);
    @(negedge clk);
    check(startErase == 1'b1 && windowClosed == 1'b1, "R4 expiry",
          int'({startErase, windowClosed}), 3);
    @(negedge clk);
    check(startErase == 1'b0, "R4 one cycle", int'(startErase), 0);
    check(sectorMask == 8'h20, "R10 mask held", int'(sectorMask), 'h20);
  endtask

  task automatic testMulti();
    bit seen;
    fullSeq(6);
    wr(secAddr(3) ^ 12'h0FF, 8'h30);
    wr(secAddr(1), 8'h30);
    check(sectorMask == 8'h4A, "R3 any order", int'(sectorMask), 'h4A);
    repeat (W - 1) @(negedge clk);
    wr(secAddr(0), 8'h30); // edge exactly W after previous write
    check(windowClosed == 1'b0 && sectorMask == 8'h4B, "R4 boundary write",
          int'(sectorMask), 'h4B);
    waitStart(seen);
    check(seen && sectorMask == 8'h4B, "R3 erase with mask", int'(sectorMask), 'h4B);
  endtask

  task automatic testRepeats();
    bit seen;
    fullSeq(2);
    fullSeq(7);
    check(sectorMask == 8'h84, "R5 full repeat", int'(sectorMask), 'h84);
    shortSeq(4);
    check(sectorMask == 8'h94, "R6 short repeat", int'(sectorMask), 'h94);
    waitStart(seen);
    check(seen, "R6 erase started", int'(seen), 1);
  endtask

  task automatic testSuspend();
    bit seen;
    fullSeq(1);
    wr(12'h000, 8'hB0);
    check(windowClosed == 1'b0 && sectorMask == 8'h02, "R8 suspend",
          int'(sectorMask), 'h02);
    waitStart(seen);
    check(seen && sectorMask == 8'h02, "R8 erase after suspend", int'(sectorMask), 'h02);
  endtask

  task automatic testAbort();
    bit seen;
    fullSeq(3);
    wr(12'h555, 8'hF0);
    check(windowClosed == 1'b1 && sectorMask == '0, "R7 abort",
          int'(sectorMask), 0);
    waitStart(seen);
    check(!seen, "R7 no erase", int'(seen), 0);
  endtask

  task automatic testBrokenRepeat();
    bit seen;
    fullSeq(3);
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h00);
    check(windowClosed == 1'b1 && sectorMask == '0, "R11 broken repeat",
          int'(sectorMask), 0);
    waitStart(seen);
    check(!seen, "R11 no erase", int'(seen), 0);
  endtask

  task automatic testOutside();
    bit seen;
    fullSeq(2);
    waitStart(seen);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h123, 8'h80);
    check(windowClosed == 1'b1 && sectorMask == 8'h04, "R9 mismatch keeps mask",
          int'(sectorMask), 'h04);
    fullSeq(5);
    check(windowClosed == 1'b0 && sectorMask == 8'h20, "R9 R10 new sequence",
          int'(sectorMask), 'h20);
    waitStart(seen);
  endtask

  task automatic testStray();
    bit seen;
    wr(secAddr(6), 8'h30);
    check(windowClosed == 1'b1 && sectorMask == 8'h20, "R12 stray ignored",
          int'(sectorMask), 'h20);
    waitStart(seen);
    check(!seen, "R12 no erase", int'(seen), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testSingle();
    testMulti();
    testRepeats();
    testSuspend();
    testAbort();
    testBrokenRepeat();
    testOutside();
    testStray();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule